// File: doc/BRIEF.md
# Oscilloscope Acquisition and Edge Trigger Controller

This block runs the capture of one channel of 8-bit samples into a 4096-entry circular sample memory and searches that stream for a level crossing. While the sampling reset is held, nothing is written. Once the reset is released, one sample is stored on every clock, and the write address wraps around the memory.

When 1600 samples have been written, a read pointer starts at address 800 and walks forward one address per clock. The pointer therefore trails the write pointer by a fixed 800 entries. Each sample read back is tested against the programmed level together with the sample read just before it, on the selected edge. Capture ends in one of two ways. If a crossing is found, writing stops and the address of the crossing sample is held. If no crossing arrives before the number of samples written reaches a programmable count, writing also stops. In both cases a done flag is raised for the host. The host reads the stored samples through a separate read port, using the held trigger address to find the point of interest.

Top module: `scope_acq_trigger`

## Requirements
- R1: While `sampRst` is high, no sample is written. `wrAddr` stays 0, and `acqDone`, `trigFound` and `trigAddr` are 0 one clock after `sampRst` is seen high.
- R2: From the first clock after `sampRst` falls, sample number k (counting from 0) is stored at address k mod 4096, one per clock. `wrAddr` shows the number of samples written mod 4096. `hostRdData` returns the word at `hostRdAddr` one clock later.
- R3: The trigger search begins only after 1600 samples are written, reading from address 800 upward one address per clock. The first comparison pairs sample 800 (previous) with sample 801 (current). A trigger found on sample n leaves exactly n+802 samples written.
- R4: With `edgeFalling` = 0, a trigger is declared when the previous sample is at or below `trigLevel` and the current sample is above it.
- R5: With `edgeFalling` = 1, a trigger is declared when the previous sample is above `trigLevel` and the current sample is at or below it.
- R6: On a trigger, writing stops and `acqDone` and `trigFound` go to 1. `trigAddr` holds the address (n mod 4096) of the current sample of the crossing pair.
- R7: With no trigger, writing stops once exactly `timeoutCount` samples (at least 1) have been written, and `acqDone` goes to 1 with `trigFound` at 0. If a trigger and the timeout fall on the same clock, the trigger is reported.
- R8: After `acqDone` is set, `acqDone`, `trigFound`, `trigAddr` and `wrAddr` keep their values, whatever the samples do, until `sampRst` is raised again.
- R9: A crossing among samples 0 to 800 never produces a trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample and control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sampRst | input | 1 | Sampling reset; capture is held idle while high |
| sampleIn | input | 8 | Incoming sample, one per clock |
| trigLevel | input | 8 | Trigger level |
| edgeFalling | input | 1 | 0 selects rising edge, 1 selects falling edge |
| timeoutCount | input | 20 | Number of samples after which capture stops if there is no trigger |
| hostRdAddr | input | 12 | Host read address into the sample memory |
| hostRdData | output | 8 | Sample at hostRdAddr, one clock later |
| wrAddr | output | 12 | Current write address |
| trigAddr | output | 12 | Memory address of the trigger sample |
| trigFound | output | 1 | Capture ended on a trigger |
| acqDone | output | 1 | Capture has stopped |

## Verification
The hardest situation to reach is a crossing that lands exactly on the clock where the sample count reaches the timeout. This tie only happens when the crossing index and the timeout value differ by precisely 802. The bench builds a sample buffer with a single crossing at address 801 and runs it twice: once with the timeout on the tie clock, and once with the timeout one clock earlier. Random buffers with random levels and edges are checked against a scan of the same buffer in the bench. A long run without a trigger pushes the write pointer past the end of memory so that wrapped readback can be checked.

// File: rtl/acq_trig_pkg.sv
package acq_trig_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic clear;       // sampling reset: clear pointers and pipeline
    logic wrEn;        // store sampleIn, advance write pointer
    logic searchStart; // load the read pointer with the search start address
    logic rdEn;        // read one sample for the trigger search
    logic capture;     // hold the address of the current compared sample
  } acqStrobes_t;

  typedef enum logic [1:0] {
    ST_FILL   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_STOP   = 2'd2
  } acqState_t;

endpackage

// File: rtl/acq_trig_dpath.sv
module acq_trig_dpath
  import acq_trig_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int ADDR_W       = 12,
  parameter int PREFILL      = 1600,
  parameter int SEARCH_START = 800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  acqStrobes_t       strobes,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic [DATA_W-1:0] trigLevel,
  input  logic              edgeFalling,
  input  logic [ADDR_W-1:0] hostRdAddr,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] hostRdData,
  output logic [ADDR_W-1:0] trigAddr,
  output logic              edgeHit
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] START_ADDR = ADDR_W'(SEARCH_START);
  localparam logic [ADDR_W-1:0] PTR_GAP    = ADDR_W'(PREFILL - SEARCH_START);

  logic [DATA_W-1:0] sampleMem [DEPTH];
  logic [ADDR_W-1:0] rdAddr;
  logic [ADDR_W-1:0] rdAddrD;
  logic [DATA_W-1:0] rdData;
  logic              rdValid;
  logic [DATA_W-1:0] prevSample;
  logic              prevValid;

  // Memory: one write port, one search read port, one host read port
  always_ff @(posedge clk) begin
    if (strobes.wrEn) begin
      sampleMem[wrAddr] <= sampleIn;
    end
    if (strobes.rdEn) begin
      rdData <= sampleMem[rdAddr];
    end
    hostRdData <= sampleMem[hostRdAddr];
  end

  // Pointers, read pipeline and held-over sample
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrAddr     <= '0;
      rdAddr     <= '0;
      rdAddrD    <= '0;
      rdValid    <= 1'b0;
      prevSample <= '0;
      prevValid  <= 1'b0;
      trigAddr   <= '0;
    end else if (strobes.clear) begin
      wrAddr     <= '0;
      rdAddr     <= '0;
      rdAddrD    <= '0;
      rdValid    <= 1'b0;
      prevSample <= '0;
      prevValid  <= 1'b0;
      trigAddr   <= '0;
    end else begin
      if (strobes.wrEn) begin
        wrAddr <= wrAddr + ADDR_W'(1);
      end
      if (strobes.searchStart) begin
        rdAddr <= START_ADDR;
      end else if (strobes.rdEn) begin
        rdAddr <= rdAddr + ADDR_W'(1);
      end
      rdValid <= strobes.rdEn;
      if (strobes.rdEn) begin
        rdAddrD <= rdAddr;
      end
      if (rdValid) begin
        prevSample <= rdData;
        prevValid  <= 1'b1;
      end
      if (strobes.capture) begin
        trigAddr <= rdAddrD;
      end
    end
  end

  // Level tests on both samples of the pair
  logic prevAtOrBelow;
  logic curAtOrBelow;
  logic riseHit;
  logic fallHit;

  always_comb begin
    prevAtOrBelow = (prevSample <= trigLevel);
    curAtOrBelow  = (rdData <= trigLevel);
    riseHit       = prevAtOrBelow && !curAtOrBelow;
    fallHit       = !prevAtOrBelow && curAtOrBelow;
    edgeHit       = rdValid && prevValid && (edgeFalling ? fallHit : riseHit);
  end

  // R3
  rd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.wrEn && strobes.rdEn) |-> ((wrAddr - rdAddr) == PTR_GAP));

  // R6
  cap_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.capture |-> (rdValid && prevValid));

endmodule

// File: rtl/acq_trig_ctrl.sv
module acq_trig_ctrl
  import acq_trig_pkg::*;
#(
  parameter int PREFILL = 1600,
  parameter int TMO_W   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sampRst,
  input  logic [TMO_W-1:0] timeoutCount,
  input  logic             edgeHit,
  output acqStrobes_t      strobes,
  output logic             acqDone,
  output logic             trigFound
);

  localparam logic [TMO_W-1:0] PREFILL_LAST = TMO_W'(PREFILL - 1);

  acqState_t        state;
  acqState_t        stateNext;
  logic [TMO_W-1:0] wrCount;
  logic             trigHit;
  logic             tmoHit;

  always_comb begin
    strobes             = '0;
    strobes.clear       = sampRst;
    strobes.wrEn        = !sampRst && (state != ST_STOP);
    strobes.rdEn        = !sampRst && (state == ST_SEARCH);
    trigHit             = strobes.rdEn && edgeHit;
    strobes.capture     = trigHit;
    strobes.searchStart = strobes.wrEn && (state == ST_FILL) &&
                          (wrCount == PREFILL_LAST);
    tmoHit              = strobes.wrEn &&
                          (wrCount == (timeoutCount - TMO_W'(1)));

    stateNext = state;
    if (trigHit || tmoHit) begin
      stateNext = ST_STOP;
    end else if (strobes.searchStart) begin
      stateNext = ST_SEARCH;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_FILL;
      wrCount   <= '0;
      trigFound <= 1'b0;
    end else if (sampRst) begin
      state     <= ST_FILL;
      wrCount   <= '0;
      trigFound <= 1'b0;
    end else begin
      state <= stateNext;
      if (strobes.wrEn) begin
        wrCount <= wrCount + TMO_W'(1);
      end
      if (trigHit) begin
        trigFound <= 1'b1;
      end
    end
  end

  assign acqDone = (state == ST_STOP);

  // R1
  rst_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sampRst |=> (!acqDone && !trigFound));

  // R6
  found_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trigFound |-> acqDone);

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acqDone && !sampRst) |=> (acqDone && $stable(trigFound)));

endmodule

// File: rtl/scope_acq_trigger.sv
module scope_acq_trigger
  import acq_trig_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int ADDR_W       = 12,
  parameter int TMO_W        = 20,
  parameter int PREFILL      = 1600,
  parameter int SEARCH_START = 800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sampRst,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic [DATA_W-1:0] trigLevel,
  input  logic              edgeFalling,
  input  logic [TMO_W-1:0]  timeoutCount,
  input  logic [ADDR_W-1:0] hostRdAddr,
  output logic [DATA_W-1:0] hostRdData,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] trigAddr,
  output logic              trigFound,
  output logic              acqDone
);

  acqStrobes_t strobes;
  logic        edgeHit;

  acq_trig_ctrl #(
    .PREFILL (PREFILL),
    .TMO_W   (TMO_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .sampRst      (sampRst),
    .timeoutCount (timeoutCount),
    .edgeHit      (edgeHit),
    .strobes      (strobes),
    .acqDone      (acqDone),
    .trigFound    (trigFound)
  );

  acq_trig_dpath #(
    .DATA_W       (DATA_W),
    .ADDR_W       (ADDR_W),
    .PREFILL      (PREFILL),
    .SEARCH_START (SEARCH_START)
  ) u_dpath (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobes     (strobes),
    .sampleIn    (sampleIn),
    .trigLevel   (trigLevel),
    .edgeFalling (edgeFalling),
    .hostRdAddr  (hostRdAddr),
    .wrAddr      (wrAddr),
    .hostRdData  (hostRdData),
    .trigAddr    (trigAddr),
    .edgeHit     (edgeHit)
  );

  // R1
  rst_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sampRst |=> (wrAddr == '0 && trigAddr == '0));

  // R8
  stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acqDone && !sampRst) |=> ($stable(wrAddr) && $stable(trigAddr)));

endmodule

// File: tb/scope_acq_trigger_bench.sv
module scope_acq_trigger_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sampRst = 1'b1;
  logic [7:0]  sampleIn = '0;
  logic [7:0]  trigLevel = '0;
  logic        edgeFalling = 1'b0;
  logic [19:0] timeoutCount = 20'd1;
  logic [11:0] hostRdAddr = '0;
  logic [7:0]  hostRdData;
  logic [11:0] wrAddr;
  logic [11:0] trigAddr;
  logic        trigFound;
  logic        acqDone;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [7:0] samp [8192];

  always #2.5 clk = ~clk;

  scope_acq_trigger u_scope_acq_trigger (
    .clk          (clk),
    .rst_n        (rst_n),
    .sampRst      (sampRst),
    .sampleIn     (sampleIn),
    .trigLevel    (trigLevel),
    .edgeFalling  (edgeFalling),
    .timeoutCount (timeoutCount),
    .hostRdAddr   (hostRdAddr),
    .hostRdData   (hostRdData),
    .wrAddr       (wrAddr),
    .trigAddr     (trigAddr),
    .trigFound    (trigFound),
    .acqDone      (acqDone)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic fillBand(input int lo, input int hi);
    for (int i = 0; i < 8192; i++) begin
      samp[i] = 8'(lo + int'($urandom % 32'(hi - lo + 1)));
    end
  endtask

  // Expected trigger index from R3/R4/R5/R7/R9; -1 when none
  function automatic int findTrig(input bit fall, input logic [7:0] lvl,
                                  input int tmo);
    for (int n = 801; n + 802 <= tmo; n++) begin
      bit prevLe = (samp[n-1] <= lvl);
      bit curLe  = (samp[n] <= lvl);
      if (fall ? (!prevLe && curLe) : (prevLe && !curLe)) return n;
    end
    return -1;
  endfunction

  task automatic hostRead(input int addr, output int data);
    @(negedge clk);
    hostRdAddr = 12'(addr);
    @(negedge clk);
    data = int'(hostRdData);
  endtask

  task automatic acquire(input bit fall, input logic [7:0] lvl, input int tmo);
    int expN, writes, rd, a, m, last, expWrAddr;
    logic [11:0] holdWr, holdTa;
    logic holdFound;
    @(negedge clk);
    sampRst = 1'b1;
    edgeFalling = fall;
    trigLevel = lvl;
    timeoutCount = 20'(tmo);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      sampleIn = 8'($urandom);
    end
    // R1: idle under sampling reset
    chk(wrAddr == 0, "R1", "wrAddr under reset", int'(wrAddr), 0);
    chk(!acqDone && !trigFound, "R1", "flags under reset",
        int'({acqDone, trigFound}), 0);
    chk(trigAddr == 0, "R1", "trigAddr under reset", int'(trigAddr), 0);

    expN = findTrig(fall, lvl, tmo);
    writes = (expN >= 0) ? expN + 802 : tmo;
    expWrAddr = writes % 4096;

    sampRst = 1'b0;
    sampleIn = samp[0];
    for (int k = 1; k < 8192; k++) begin
      @(negedge clk);
      if (acqDone) break;
      sampleIn = samp[k];
    end

    chk(acqDone == 1'b1, "R7", "acqDone after capture", int'(acqDone), 1);
    if (expN >= 0) begin
      chk(trigFound == 1'b1, "R6", "trigFound", int'(trigFound), 1);
      chk(trigAddr == 12'(expN % 4096), "R6", "trigAddr", int'(trigAddr),
          expN % 4096);
      chk(wrAddr == 12'(expWrAddr), "R3", "writes after trigger",
          int'(wrAddr), expWrAddr);
    end else begin
      chk(trigFound == 1'b0, "R7", "trigFound on timeout", int'(trigFound), 0);
      chk(wrAddr == 12'(expWrAddr), "R7", "writes at timeout",
          int'(wrAddr), expWrAddr);
    end

    // R2: readback of the newest word and one other written address
    last = (writes - 1) % 4096;
    hostRead(last, rd);
    chk(rd == int'(samp[writes - 1]), "R2", "readback newest", rd,
        int'(samp[writes - 1]));
    a = int'($urandom % 32'((writes < 4096) ? writes : 4096));
    m = a + 4096 * ((writes - 1 - a) / 4096);
    hostRead(a, rd);
    chk(rd == int'(samp[m]), "R2", "readback random addr", rd, int'(samp[m]));

    // R8: crossings after the stop change nothing
    holdWr = wrAddr;
    holdTa = trigAddr;
    holdFound = trigFound;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      sampleIn = (i % 2 == 0) ? 8'd0 : 8'd255;
    end
    chk(acqDone && trigFound == holdFound && trigAddr == holdTa &&
        wrAddr == holdWr, "R8", "state held after stop",
        int'({acqDone, trigFound, trigAddr}),
        int'({1'b1, holdFound, holdTa}));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R4: rising crossing at 1200, all earlier samples at or below level
    fillBand(0, 100);
    samp[1200] = 8'd101;
    acquire(1'b0, 8'd100, 8000);

    // R5: falling crossing where the current sample equals the level
    fillBand(61, 255);
    samp[2499] = 8'd61;
    samp[2500] = 8'd60;
    acquire(1'b1, 8'd60, 8000);

    // R3: first possible comparison pair 800 -> 801
    fillBand(0, 128);
    samp[800] = 8'd128;
    samp[801] = 8'd129;
    acquire(1'b0, 8'd128, 8000);

    // R7: tie between trigger and timeout; trigger wins
    acquire(1'b0, 8'd128, 1603);
    // R7: timeout one clock before the trigger
    acquire(1'b0, 8'd128, 1602);

    // R9: crossing before the search window is ignored
    fillBand(51, 255);
    for (int i = 0; i < 300; i++) samp[i] = 8'(i % 51);
    acquire(1'b0, 8'd50, 3000);

    // R7: timeout shorter than the pre-fill
    fillBand(0, 255);
    acquire(1'b1, 8'd128, 1000);

    // R2: wrap past the end of memory, rising with level 255 never fires
    fillBand(0, 255);
    acquire(1'b0, 8'd255, 5000);

    // R4 R5: random buffers, levels and edges
    for (int t = 0; t < 5; t++) begin
      fillBand(0, 255);
      acquire(1'($urandom), 8'($urandom), 1700 + int'($urandom % 3000));
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule